// File: doc/BRIEF.md
# Dual-Width Arithmetic Unit with Carry and Zero Status

This block is the execution stage of a small processor. It takes two operands, a 4-bit operation code and a byte/word select. One clock later it returns a registered result, a write strobe for that result, and a one-cycle divide-by-zero exception. It also holds a two-bit status register with a carry flag and a zero flag. The flags change only for operations that are defined to affect them. Operand fetch and address computation are done upstream.

In byte mode, only the low byte of each operand takes part, and all arithmetic and flags are computed at 8 bits. All arithmetic is unsigned. Multiply and divide treat `opa` as the accumulator. The caller supplies the accumulator's contents there and routes a written result back to the accumulator: the full register in word mode, its low byte in byte mode.

Operation codes on `op`: 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 NOT (uses `opa`), 7 shift left, 8 shift right, 9 increment (`opa`), 10 decrement (`opa`), 11 multiply, 12 divide. Codes 13 to 15 are unused.

Top module: `dual_alu`

## Requirements
- R1: A request accepted with `in_valid` high produces `res_valid` high on the following cycle, with all outputs registered; without a request, `res_valid` and `div_zero_exc` stay low.
- R2: Add (0) and increment (9) write the truncated sum. C is set when the true sum exceeds the selected width, and Z is set when the truncated sum is zero.
- R3: Subtract (1) and decrement (10) write `opa` minus the second operand, truncated. C is set on borrow and Z is set on a zero result.
- R4: Compare (2) writes nothing (`res_we` low) and leaves C,Z at 0,1 for equal operands, 0,0 when `opa` is greater, and 1,0 when `opa` is smaller.
- R5: AND (3), OR (4), XOR (5) and NOT (6) write their result and leave both flags unchanged.
- R6: Multiply (11) writes the truncated product of accumulator and operand. C is set when the full product does not fit the width, and Z reflects the truncated product.
- R7: Divide (12) writes the integer quotient with C cleared and Z from the quotient. A zero divisor instead pulses `div_zero_exc` for one cycle, with `res_we` low and both flags unchanged.
- R8: Shifts (7 left, 8 right) are logical by the amount in the second operand. C is the last bit shifted out. An amount of zero returns `opa` with C clear. An amount above the width returns zero with C clear.
- R9: In byte mode (`byte_mode`=1), operand bits above bit 7 are ignored, result bits above bit 7 are zero, and carry and zero are judged at 8 bits.
- R10: Unused codes 13 to 15 write nothing and leave the flags unchanged.
- R11: After reset, `flag_c`, `flag_z`, `res_valid`, `res_we` and `div_zero_exc` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| opa | input | 16 | First operand / accumulator |
| opb | input | 16 | Second operand / shift amount / divisor |
| res_valid | output | 1 | Result slot valid |
| res_data | output | 16 | Result value |
| res_we | output | 1 | Result must be written to the destination |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| div_zero_exc | output | 1 | Divide-by-zero exception pulse |

## Verification
On every cycle, the assertions check:
- the one-cycle response timing;
- that compare never writes and never reports C and Z together;
- that logic operations and unused codes keep the flags;
- the divide-by-zero contract, including a byte divisor that is zero only in its low byte;
- that the upper result byte is clear in byte mode.

The actual values only the bench's scenarios can show:
- sums, borrows, products, quotients and shifted-out bits;
- the three compare orderings;
- the zero-amount and over-width shift cases.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_NOT = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10,
    OP_MUL = 4'd11,
    OP_DIV = 4'd12
  } alu_op_e;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath #(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [3:0]        op,
  input  logic              byte_mode,
  input  logic [WIDE_W-1:0] opa,
  input  logic [WIDE_W-1:0] opb,
  output logic [WIDE_W-1:0] result,
  output logic              c_out,
  output logic              z_out,
  output logic              do_write,
  output logic              do_flags,
  output logic              div_zero
);
  import alu_pkg::*;

  localparam logic [WIDE_W-1:0] WIDE_MASK   = {WIDE_W{1'b1}};
  localparam logic [WIDE_W-1:0] NARROW_MASK = WIDE_W'((1 << NARROW_W) - 1);
  localparam logic [WIDE_W-1:0] WIDE_LIM    = WIDE_W'(WIDE_W);
  localparam logic [WIDE_W-1:0] NARROW_LIM  = WIDE_W'(NARROW_W);
  localparam logic [WIDE_W-1:0] ONE         = WIDE_W'(1);

  // {carry, result}
  function automatic logic [WIDE_W:0] add_fn(input logic [WIDE_W-1:0] a,
                                             input logic [WIDE_W-1:0] b,
                                             input logic [WIDE_W-1:0] m);
    logic [WIDE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return {|(s & ~{1'b0, m}), s[WIDE_W-1:0] & m};
  endfunction

  function automatic logic [WIDE_W:0] sub_fn(input logic [WIDE_W-1:0] a,
                                             input logic [WIDE_W-1:0] b,
                                             input logic [WIDE_W-1:0] m);
    return {(a < b), (a - b) & m};
  endfunction

  function automatic logic [WIDE_W:0] mul_fn(input logic [WIDE_W-1:0] a,
                                             input logic [WIDE_W-1:0] b,
                                             input logic [WIDE_W-1:0] m);
    logic [2*WIDE_W-1:0] p;
    p = {{WIDE_W{1'b0}}, a} * {{WIDE_W{1'b0}}, b};
    return {|(p & ~{{WIDE_W{1'b0}}, m}), p[WIDE_W-1:0] & m};
  endfunction

  function automatic logic [WIDE_W:0] shl_fn(input logic [WIDE_W-1:0] a,
                                             input logic [WIDE_W-1:0] n,
                                             input logic [WIDE_W-1:0] w,
                                             input logic [WIDE_W-1:0] m);
    logic [WIDE_W-1:0] t;
    logic [WIDE_W-1:0] top;
    if (n == '0) return {1'b0, a};
    if (n > w) return '0;
    t   = a << (n - ONE);
    top = t >> (w - ONE);
    return {top[0], (t << 1) & m};
  endfunction

  function automatic logic [WIDE_W:0] shr_fn(input logic [WIDE_W-1:0] a,
                                             input logic [WIDE_W-1:0] n,
                                             input logic [WIDE_W-1:0] w);
    logic [WIDE_W-1:0] t;
    if (n == '0) return {1'b0, a};
    if (n > w) return '0;
    t = a >> (n - ONE);
    return {t[0], t >> 1};
  endfunction

  logic [WIDE_W-1:0] m, w, a, b;

  always_comb begin
    m        = byte_mode ? NARROW_MASK : WIDE_MASK;
    w        = byte_mode ? NARROW_LIM  : WIDE_LIM;
    a        = opa & m;
    b        = opb & m;
    result   = '0;
    c_out    = 1'b0;
    do_write = 1'b0;
    do_flags = 1'b0;
    div_zero = 1'b0;
    case (op)
      OP_ADD: begin {c_out, result} = add_fn(a, b, m);   do_write = 1'b1; do_flags = 1'b1; end
      OP_INC: begin {c_out, result} = add_fn(a, ONE, m); do_write = 1'b1; do_flags = 1'b1; end
      OP_SUB: begin {c_out, result} = sub_fn(a, b, m);   do_write = 1'b1; do_flags = 1'b1; end
      OP_DEC: begin {c_out, result} = sub_fn(a, ONE, m); do_write = 1'b1; do_flags = 1'b1; end
      OP_CMP: begin {c_out, result} = sub_fn(a, b, m);   do_flags = 1'b1; end
      OP_AND: begin result = a & b;  do_write = 1'b1; end
      OP_OR:  begin result = a | b;  do_write = 1'b1; end
      OP_XOR: begin result = a ^ b;  do_write = 1'b1; end
      OP_NOT: begin result = ~a & m; do_write = 1'b1; end
      OP_SHL: begin {c_out, result} = shl_fn(a, b, w, m); do_write = 1'b1; do_flags = 1'b1; end
      OP_SHR: begin {c_out, result} = shr_fn(a, b, w);    do_write = 1'b1; do_flags = 1'b1; end
      OP_MUL: begin {c_out, result} = mul_fn(a, b, m);    do_write = 1'b1; do_flags = 1'b1; end
      OP_DIV: begin
        if (b == '0) begin
          div_zero = 1'b1;
        end else begin
          result   = a / b;
          do_write = 1'b1;
          do_flags = 1'b1;
        end
      end
      default: ;
    endcase
    z_out = (result == '0);
  end
endmodule

// File: rtl/alu_status.sv
module alu_status (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic c_in,
  input  logic z_in,
  output logic flag_c,
  output logic flag_z
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_c <= 1'b0;
      flag_z <= 1'b0;
    end else if (upd) begin
      flag_c <= c_in;
      flag_z <= z_in;
    end
  end
endmodule

// File: rtl/dual_alu.sv
module dual_alu #(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic              byte_mode,
  input  logic [WIDE_W-1:0] opa,
  input  logic [WIDE_W-1:0] opb,
  output logic              res_valid,
  output logic [WIDE_W-1:0] res_data,
  output logic              res_we,
  output logic              flag_c,
  output logic              flag_z,
  output logic              div_zero_exc
);
  logic [WIDE_W-1:0] dp_result;
  logic dp_c, dp_z, dp_write, dp_flags, dp_divz;

  // Named events, qualified by the request strobe.
  logic ev_flag_upd, ev_write, ev_div_zero;
  assign ev_flag_upd = in_valid & dp_flags;
  assign ev_write    = in_valid & dp_write;
  assign ev_div_zero = in_valid & dp_divz;

  alu_datapath #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) dp_i (
    .op(op), .byte_mode(byte_mode), .opa(opa), .opb(opb),
    .result(dp_result), .c_out(dp_c), .z_out(dp_z),
    .do_write(dp_write), .do_flags(dp_flags), .div_zero(dp_divz)
  );

  alu_status st_i (
    .clk(clk), .rst_n(rst_n), .upd(ev_flag_upd),
    .c_in(dp_c), .z_in(dp_z), .flag_c(flag_c), .flag_z(flag_z)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_we       <= 1'b0;
      div_zero_exc <= 1'b0;
    end else begin
      res_valid    <= in_valid;
      res_we       <= ev_write;
      div_zero_exc <= ev_div_zero;
      if (in_valid) res_data <= dp_result;
    end
  end
endmodule

// File: rtl/dual_alu_chk.sv
module dual_alu_chk #(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        op,
  input logic              byte_mode,
  input logic [WIDE_W-1:0] opb,
  input logic              res_valid,
  input logic [WIDE_W-1:0] res_data,
  input logic              res_we,
  input logic              flag_c,
  input logic              flag_z,
  input logic              div_zero_exc,
  input logic              ev_flag_upd
);
  logic [WIDE_W-1:0] divisor;
  assign divisor = byte_mode ? (opb & WIDE_W'((1 << NARROW_W) - 1)) : opb;

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && !div_zero_exc && !res_we));
  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd2) |=> !res_we);
  p_cmp_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd2) |=> !(flag_c && flag_z));
  p_logic_keeps_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd3 && op <= 4'd6) |=> ($stable(flag_c) && $stable(flag_z) && res_we));
  p_div_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd12 && divisor == '0) |=>
      (div_zero_exc && !res_we && $stable(flag_c) && $stable(flag_z)));
  p_exc_needs_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && op == 4'd12) |=> !div_zero_exc);
  p_byte_upper_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && byte_mode) |=> ((res_data >> NARROW_W) == '0));
  p_unused_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd13) |=> (!res_we && $stable(flag_c) && $stable(flag_z)));
  p_flags_only_on_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_flag_upd |=> ($stable(flag_c) && $stable(flag_z)));
endmodule

bind dual_alu dual_alu_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .byte_mode(byte_mode),
  .opb(opb), .res_valid(res_valid), .res_data(res_data), .res_we(res_we),
  .flag_c(flag_c), .flag_z(flag_z), .div_zero_exc(div_zero_exc),
  .ev_flag_upd(ev_flag_upd)
);

// File: tb/dual_alu_tb.sv
`timescale 1ns/1ps
module dual_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] op = '0;
  logic byte_mode = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic res_valid, res_we, flag_c, flag_z, div_zero_exc;
  logic [15:0] res_data;

  always #4 clk = ~clk;

  dual_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .byte_mode(byte_mode),
    .opa(opa), .opb(opb), .res_valid(res_valid), .res_data(res_data), .res_we(res_we),
    .flag_c(flag_c), .flag_z(flag_z), .div_zero_exc(div_zero_exc)
  );

  typedef struct {
    logic        we;
    logic [15:0] data;
    logic        c;
    logic        z;
    logic        exc;
    string       req;
  } exp_t;

  exp_t sb[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic mc = 1'b0, mz = 1'b0;

  // Reference model written with plain integer arithmetic.
  function automatic exp_t model(input int code, input bit bm, input int x, input int y, input string req);
    exp_t e;
    longint w, m, a, b, r, p;
    bit c, upd, wr, exc;
    w = bm ? 8 : 16;
    m = (longint'(1) << w) - 1;
    a = x & m; b = y & m;
    r = 0; c = 0; upd = 0; wr = 0; exc = 0;
    case (code)
      0:  begin r = (a + b) & m; c = (a + b) > m; upd = 1; wr = 1; end
      9:  begin r = (a + 1) & m; c = (a + 1) > m; upd = 1; wr = 1; end
      1:  begin r = (a - b) & m; c = a < b; upd = 1; wr = 1; end
      10: begin r = (a - 1) & m; c = a < 1; upd = 1; wr = 1; end
      2:  begin r = (a - b) & m; c = a < b; upd = 1; end
      3:  begin r = a & b; wr = 1; end
      4:  begin r = a | b; wr = 1; end
      5:  begin r = a ^ b; wr = 1; end
      6:  begin r = (~a) & m; wr = 1; end
      7:  begin
            upd = 1; wr = 1;
            if (b == 0) r = a;
            else if (b <= w) begin c = ((a >> (w - b)) & 1) != 0; r = (a << b) & m; end
          end
      8:  begin
            upd = 1; wr = 1;
            if (b == 0) r = a;
            else if (b <= w) begin c = ((a >> (b - 1)) & 1) != 0; r = a >> b; end
          end
      11: begin p = a * b; r = p & m; c = p > m; upd = 1; wr = 1; end
      12: begin
            if (b == 0) exc = 1;
            else begin r = a / b; upd = 1; wr = 1; end
          end
      default: ;
    endcase
    if (upd) begin mc = c; mz = (r == 0); end
    e.we = wr; e.data = 16'(r); e.c = mc; e.z = mz; e.exc = exc; e.req = req;
    return e;
  endfunction

  task automatic apply(input int code, input bit bm, input int x, input int y, input string req);
    @(negedge clk);
    in_valid = 1'b1; op = 4'(code); byte_mode = bm; opa = 16'(x); opb = 16'(y);
    sb.push_back(model(code, bm, x, y, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compare each produced result against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      exp_t e;
      n_checks++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R1 unexpected result: actual res_valid=1 expected 0");
      end else begin
        e = sb.pop_front();
        if (res_we !== e.we || (e.we && res_data !== e.data) || flag_c !== e.c ||
            flag_z !== e.z || div_zero_exc !== e.exc) begin
          n_fail++;
          $display("FAIL %s actual we=%0b data=%h c=%0b z=%0b exc=%0b expected we=%0b data=%h c=%0b z=%0b exc=%0b",
                   e.req, res_we, res_data, flag_c, flag_z, div_zero_exc,
                   e.we, e.data, e.c, e.z, e.exc);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++; // R11 reset state
    if ({flag_c, flag_z, res_valid, res_we, div_zero_exc} !== 5'b0) begin
      n_fail++;
      $display("FAIL R11 actual %b expected 00000", {flag_c, flag_z, res_valid, res_we, div_zero_exc});
    end
    rst_n = 1'b1;
    idle(2);
    // R2 add / increment
    apply(0, 0, 16'h1234, 16'h1111, "R2 add plain");
    apply(0, 0, 16'hFFFF, 16'h0001, "R2 add wrap");
    apply(9, 0, 16'hFFFF, 0, "R2 inc wrap");
    apply(9, 0, 16'h00FF, 0, "R2 inc plain");
    // R9 byte mode add with high garbage
    apply(0, 1, 16'hAB80, 16'hCD80, "R9 byte add carry");
    apply(0, 1, 16'h1201, 16'h3402, "R9 byte add high ignored");
    // R3 subtract / decrement
    apply(1, 0, 5, 7, "R3 sub borrow");
    apply(1, 0, 9, 9, "R3 sub zero");
    apply(10, 0, 0, 0, "R3 dec borrow");
    apply(10, 1, 16'h7701, 0, "R3 byte dec zero");
    idle(2);
    // R4 compare orderings
    apply(2, 0, 16'h0500, 16'h0500, "R4 cmp equal");
    apply(2, 0, 16'h0501, 16'h0500, "R4 cmp greater");
    apply(2, 0, 16'h04FF, 16'h0500, "R4 cmp smaller");
    apply(2, 1, 16'h12FF, 16'h34FF, "R4 R9 byte cmp equal");
    apply(2, 0, 3, 4, "R4 cmp set carry");
    // R5 logic keeps C=1,Z=0
    apply(3, 0, 16'hF0F0, 16'h0FF0, "R5 and");
    apply(4, 0, 16'hF000, 16'h000F, "R5 or");
    apply(5, 0, 16'hAAAA, 16'hAAAA, "R5 xor zero result keeps flags");
    apply(6, 0, 16'h00FF, 0, "R5 not");
    apply(6, 1, 16'h120F, 0, "R5 R9 byte not");
    // R6 multiply
    apply(11, 0, 3, 5, "R6 mul plain");
    apply(11, 0, 16'h0100, 16'h0100, "R6 mul overflow");
    apply(11, 1, 16'h0010, 16'h0010, "R6 byte mul overflow");
    // R7 divide
    apply(12, 0, 100, 7, "R7 div");
    apply(12, 0, 3, 7, "R7 div zero quotient");
    apply(2, 0, 1, 2, "R4 cmp before div by zero");
    apply(12, 0, 50, 0, "R7 div by zero");
    apply(12, 1, 50, 16'h0100, "R7 R9 byte div by zero");
    idle(1);
    // R8 shifts
    apply(7, 0, 16'h8001, 1, "R8 shl by one");
    apply(7, 0, 16'h1234, 0, "R8 shl by zero");
    apply(7, 0, 16'hFFFF, 17, "R8 shl beyond width");
    apply(8, 0, 16'h0003, 1, "R8 shr by one");
    apply(8, 0, 16'h8000, 16, "R8 shr full width");
    apply(7, 1, 16'h0081, 8, "R8 R9 byte shl full width");
    apply(8, 1, 16'hFF40, 7, "R8 R9 byte shr");
    // R10 unused codes keep flags
    apply(13, 0, 16'hFFFF, 16'hFFFF, "R10 code 13");
    apply(15, 1, 0, 0, "R10 code 15");
    idle(4);
    n_checks++; // R1 every request answered
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1 pending results: actual %0d expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule